// File: doc/BRIEF.md
# Passive Camera Line Capture Engine

This block listens to the 8-bit parallel pixel bus of an image sensor that already runs in continuous capture mode, and it never drives the sensor. On the sensor's pixel clock it takes a byte whenever the data-valid strobe is high. It packs each pair of bytes into a 16-bit word and writes the word into an on-chip dual-clock buffer large enough to hold one line. A separate drain stage, clocked by the memory clock, empties that buffer into external memory.

Software arms the engine with a one-cycle start pulse. Capture begins only on the next rising edge of data-valid, so a line already in progress is never stored. Each falling edge of data-valid closes a line. After the configured number of lines the engine stops by itself and reports the frame as complete. The downstream memory may be too slow to store whole lines. For that case a per-line byte limit keeps only the first bytes of each line and drops the rest, which leaves the blanking gap free for the memory to catch up.

Top module: `cam_line_capture`

## Requirements
- R1: After reset, busy, frame_done and overflow are 0, lines_done is 0 and rd_empty is 1.
- R2: Bytes presented before a start pulse are ignored. After start, busy rises and lines_done reads 0, and a line whose data-valid is already high at arming is ignored in full. Capture begins with the byte at the next rising edge of data-valid.
- R3: A byte is taken only in a cycle where pix_valid is 1. Two taken bytes in a row form one word, with the first byte in rd_data[7:0] and the second in rd_data[15:8].
- R4: Within one line only the first keep_limit bytes are taken and later bytes are dropped. The limit applies again from zero on every line.
- R5: If a line ends after an odd number of taken bytes, the last unpaired byte is discarded and the next line starts a fresh pair.
- R6: lines_done increments on each falling edge of pix_valid while capturing. When it reaches LINES, frame_done becomes 1 and busy becomes 0. No further words are written, and lines_done holds until the next start.
- R7: Words leave on the memory clock in the order they were written, each appearing once. rd_en while rd_empty is 1 has no effect.
- R8: A completed word that meets a full buffer is discarded and sets overflow. Overflow stays set until a start pulse is accepted.
- R9: A start pulse while busy is 1 is ignored. The frame in progress continues, and its line count and data are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Sensor pixel clock |
| prst_n | input | 1 | Active-low reset, pixel clock domain |
| start | input | 1 | One-cycle arm pulse, pixel clock domain |
| pix_valid | input | 1 | Sensor data-valid strobe |
| pix_data | input | 8 | Sensor pixel byte |
| keep_limit | input | CW | Bytes kept per line |
| busy | output | 1 | Armed or capturing |
| frame_done | output | 1 | Frame of LINES lines stored |
| overflow | output | 1 | Sticky: a word was lost to a full buffer |
| lines_done | output | LW | Lines closed in the current frame |
| mclk | input | 1 | Memory-side clock |
| mrst_n | input | 1 | Active-low reset, memory clock domain |
| rd_en | input | 1 | Pop the head word |
| rd_data | output | 16 | Head word (show-ahead) |
| rd_empty | output | 1 | Buffer empty as seen from the memory side |

## Verification
A wrong pair phase or packing order shows up as swapped or shifted bytes in the very first word drained from a line, within a few memory-clock cycles. A pixel counter that is not cleared at line end, or a bad limit compare, shows up in the following line as too many or too few words. A miscounted line total shows at lines_done, and at frame_done going high one line early or late. Faults in pointer or synchronizer handling show up as repeated, lost or reordered words, or as an overflow flag raised while the memory side keeps pace with the writes.

// File: rtl/cam_line_capture.sv
module cam_line_capture #(
  parameter int LINES = 480,
  parameter int AW    = 9,
  parameter int CW    = 16,
  localparam int LW   = $clog2(LINES + 1)
) (
  input  logic          pclk,
  input  logic          prst_n,
  input  logic          start,
  input  logic          pix_valid,
  input  logic [7:0]    pix_data,
  input  logic [CW-1:0] keep_limit,
  output logic          busy,
  output logic          frame_done,
  output logic          overflow,
  output logic [LW-1:0] lines_done,
  input  logic          mclk,
  input  logic          mrst_n,
  input  logic          rd_en,
  output logic [15:0]   rd_data,
  output logic          rd_empty
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_RUN, S_DONE} st_t;
  st_t st;

  logic          v_q, half_q, ovf_q;
  logic [7:0]    lo_q;
  logic [CW-1:0] pcnt;
  logic [LW-1:0] lcnt;
  logic [15:0]   mem [DEPTH];
  logic [AW:0]   wbin, wgray, rg_s1, rg_s2;
  logic [AW:0]   rbin, rgray, wg_s1, wg_s2;

  wire rise     = pix_valid & ~v_q;
  wire fall     = ~pix_valid & v_q;
  wire take     = pix_valid & (pcnt < keep_limit) &
                  ((st == S_RUN) | ((st == S_ARM) & rise));
  wire push     = take & half_q;
  wire full     = wgray == {~rg_s2[AW:AW-1], rg_s2[AW-2:0]};
  wire wr_ok    = push & ~full;
  wire line_end = (st == S_RUN) & fall;
  wire [AW:0] wbin_n = wbin + 1'b1;
  wire [AW:0] rbin_n = rbin + 1'b1;

  always_ff @(posedge pclk) begin
    if (wr_ok) mem[wbin[AW-1:0]] <= {pix_data, lo_q};
  end

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      st <= S_IDLE;
      v_q <= 1'b0;
      half_q <= 1'b0;
      ovf_q <= 1'b0;
      lo_q <= '0;
      pcnt <= '0;
      lcnt <= '0;
      wbin <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      v_q <= pix_valid;
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_ok) begin
        wbin <= wbin_n;
        wgray <= wbin_n ^ (wbin_n >> 1);
      end
      if (push & full) ovf_q <= 1'b1;
      if (take) begin
        pcnt <= pcnt + 1'b1;
        if (!half_q) lo_q <= pix_data;
        half_q <= ~half_q;
      end
      case (st)
        S_IDLE, S_DONE:
          if (start) begin
            st <= S_ARM;
            lcnt <= '0;
            ovf_q <= 1'b0;
            pcnt <= '0;
            half_q <= 1'b0;
          end
        S_ARM:
          if (rise) st <= S_RUN;
        default:
          if (line_end) begin
            pcnt <= '0;
            half_q <= 1'b0;
            lcnt <= lcnt + 1'b1;
            if (lcnt == LW'(LINES - 1)) st <= S_DONE;
          end
      endcase
    end
  end

  always_ff @(posedge mclk or negedge mrst_n) begin
    if (!mrst_n) begin
      rbin <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (rd_en && !rd_empty) begin
        rbin <= rbin_n;
        rgray <= rbin_n ^ (rbin_n >> 1);
      end
    end
  end

  assign rd_empty   = rgray == wg_s2;
  assign rd_data    = mem[rbin[AW-1:0]];
  assign busy       = (st == S_ARM) | (st == S_RUN);
  assign frame_done = st == S_DONE;
  assign overflow   = ovf_q;
  assign lines_done = lcnt;

  AST_PTR_STEP: assert property (@(posedge pclk) disable iff (!prst_n)
    1'b1 |=> (wbin == $past(wbin)) || (wbin == $past(wbin) + 1'b1)); // R7
  AST_FULL_HOLD: assert property (@(posedge pclk) disable iff (!prst_n)
    full |=> wbin == $past(wbin)); // R8
  AST_OVF_STICKY: assert property (@(posedge pclk) disable iff (!prst_n)
    overflow && !start |=> overflow); // R8
  AST_LINE_BOUND: assert property (@(posedge pclk) disable iff (!prst_n)
    lines_done <= LW'(LINES)); // R6
  AST_DONE_HOLD: assert property (@(posedge pclk) disable iff (!prst_n)
    frame_done && !start |=> frame_done && $stable(lines_done) && $stable(wbin)); // R6
  AST_ARM_CLEAN: assert property (@(posedge pclk) disable iff (!prst_n)
    $rose(busy) |-> lines_done == '0 && !overflow); // R2
  AST_EMPTY_NO_POP: assert property (@(posedge mclk) disable iff (!mrst_n)
    rd_empty |=> $stable(rbin)); // R7
endmodule

// File: tb/cam_line_capture_tb.sv
module cam_line_capture_tb;
  localparam int LINES = 3;
  localparam int AW = 4;
  localparam int CW = 8;
  localparam int LW = $clog2(LINES + 1);

  logic pclk = 0, mclk = 0, prst_n = 0, mrst_n = 0;
  logic start = 0, pix_valid = 0, rd_en = 0;
  logic [7:0] pix_data = 0;
  logic [CW-1:0] keep_limit = 0;
  logic busy, frame_done, overflow, rd_empty;
  logic [LW-1:0] lines_done;
  logic [15:0] rd_data;

  int total = 0, bad = 0;
  bit rd_hold = 1;
  logic [15:0] q[$];

  always #2.5 pclk = ~pclk;
  always #3.5 mclk = ~mclk;

  cam_line_capture #(.LINES(LINES), .AW(AW), .CW(CW)) u_dut (
    .pclk(pclk), .prst_n(prst_n), .start(start), .pix_valid(pix_valid),
    .pix_data(pix_data), .keep_limit(keep_limit), .busy(busy),
    .frame_done(frame_done), .overflow(overflow), .lines_done(lines_done),
    .mclk(mclk), .mrst_n(mrst_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int kept_bytes(input int len, input int cap);
    return (len < cap) ? len : cap;
  endfunction

  function automatic logic [15:0] pack(input logic [7:0] first, input logic [7:0] second);
    return {second, first};
  endfunction

  always begin
    @(negedge mclk);
    if (!rd_hold && !rd_empty) begin
      if (q.size() == 0) chk(0, "R7 unexpected word", rd_data, 0);
      else begin
        logic [15:0] e;
        e = q.pop_front();
        chk(rd_data == e, "R3/R4/R5/R7 word", rd_data, e);
      end
      rd_en = 1;
    end else rd_en = 0;
  end

  task automatic pulse_start();
    @(negedge pclk) start = 1;
    @(negedge pclk) start = 0;
  endtask

  task automatic send_line(input int len, input bit expect_data, input int maxw, input int start_at);
    logic [7:0] b[64];
    int n;
    for (int i = 0; i < len; i++) b[i] = 8'($urandom);
    if (expect_data) begin
      n = kept_bytes(len, int'(keep_limit)) / 2;
      if (n > maxw) n = maxw;
      for (int k = 0; k < n; k++) q.push_back(pack(b[2*k], b[2*k+1]));
    end
    for (int i = 0; i < len; i++) begin
      @(negedge pclk);
      pix_valid = 1;
      pix_data = b[i];
      start = (i == start_at);
    end
    @(negedge pclk);
    pix_valid = 0;
    start = 0;
    repeat (6) @(negedge pclk);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 3000 && (q.size() != 0 || !rd_empty); i++) @(negedge mclk);
    repeat (10) @(negedge mclk);
    chk(q.size() == 0 && rd_empty, req, q.size(), 0);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge pclk);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    void'($urandom(32'd7));
    repeat (4) @(negedge pclk);
    prst_n = 1;
    mrst_n = 1;
    @(negedge pclk);
    chk(!busy && !frame_done && !overflow, "R1 flags", {busy, frame_done, overflow}, 0);
    chk(lines_done == 0 && rd_empty, "R1 count/empty", lines_done, 0);
    rd_hold = 0;

    keep_limit = 10;
    send_line(12, 0, 0, -1);
    repeat (10) @(negedge mclk);
    chk(rd_empty && lines_done == 0, "R2 before start", lines_done, 0);

    @(negedge pclk);
    pix_valid = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge pclk);
      pix_data = 8'($urandom);
      start = (i == 3);
    end
    @(negedge pclk);
    start = 0;
    pix_valid = 0;
    repeat (6) @(negedge pclk);
    repeat (10) @(negedge mclk);
    chk(busy && lines_done == 0, "R2 armed", lines_done, 0);
    chk(rd_empty, "R2 partial line ignored", rd_empty, 1);

    send_line(8, 1, 99, -1);
    chk(lines_done == 1, "R6 first line", lines_done, 1);
    send_line(25, 1, 99, 14);
    chk(lines_done == 2 && busy, "R9 start while busy", lines_done, 2);
    send_line(7, 1, 99, -1);
    chk(frame_done && !busy && lines_done == 3, "R6 frame done", lines_done, 3);
    drain("R4/R5 drain");
    send_line(10, 0, 0, -1);
    repeat (10) @(negedge mclk);
    chk(rd_empty && lines_done == 3, "R6 halt after frame", lines_done, 3);

    for (int f = 0; f < 6; f++) begin
      keep_limit = CW'(2 + $urandom % 20);
      pulse_start();
      chk(busy && lines_done == 0, "R2 rearm", lines_done, 0);
      for (int l = 0; l < LINES; l++) send_line(1 + $urandom % 30, 1, 99, -1);
      chk(frame_done && lines_done == LINES, "R6 random frame", lines_done, LINES);
      drain("R3/R4 random drain");
    end

    rd_hold = 1;
    keep_limit = 60;
    pulse_start();
    send_line(38, 1, 16, -1);
    chk(overflow, "R8 overflow set", overflow, 1);
    rd_hold = 0;
    drain("R8 kept words");
    chk(overflow, "R8 sticky", overflow, 1);
    send_line(4, 1, 99, -1);
    send_line(6, 1, 99, -1);
    chk(frame_done, "R6 overflow frame done", frame_done, 1);
    drain("R7 drain");
    pulse_start();
    chk(!overflow && busy, "R8 cleared by start", overflow, 0);

    finish_up();
  end
endmodule